// File: doc/BRIEF.md
# Delta-Sigma SINC Decimation Cascade

This block turns up to four 1-bit delta-sigma modulator streams into wide signed samples at a lower rate. Each stream is filtered by a chain of boxcar-cascade (comb-integrator) sections. A fixed fifth-order section always reduces the rate by 8. Two optional fourth-order sections, one dividing by 2 and one dividing by 5, can be added after it. A two-bit select picks one of four total ratios: 8, 16, 40 or 80.

All channels share one phase counter per section, so every channel emits its sample on the same strobe. The modulator rate, which is typically 512 kHz or 256 kHz, is set only by how often `mod_stb` is pulsed. The block needs no other rate setting. A `sync` pulse clears every section so that later outputs fall on a known boundary. The first few outputs after a `sync` are flagged as settling.

Top module: `sinc_decim_cascade`

## Requirements
- R1: With `ratio_sel` = 2'b00, each channel's output is the input stream filtered by five cascaded 8-sample moving sums and taken every 8th strobe. Bit 1 counts as +1 and bit 0 counts as -1. History before the last `sync` counts as zero. Output m covers inputs up to index 8m+7.
- R2: With `ratio_sel` = 2'b01, the R1 result is further filtered by four cascaded 2-sample moving sums and taken every 2nd result, giving a total ratio of 16.
- R3: With `ratio_sel` = 2'b10, the R1 result is further filtered by four cascaded 5-sample moving sums and taken every 5th result, giving a total ratio of 40.
- R4: With `ratio_sel` = 2'b11, both the ratio-2 and the ratio-5 sections follow the first section in that order, giving a total ratio of 80.
- R5: Channels are computed independently. Channel c occupies `out_data[c*33 +: 33]`, and all channels share the single `out_valid`.
- R6: A cycle with `sync` high clears all filter state and phase, and any strobe in that same cycle is discarded. The next cycle has `out_valid` low, and later outputs match a fresh start.
- R7: `out_valid` is a one-cycle pulse. With a strobe every cycle, output j after `sync` appears (ratio·(j+1) + number of active sections − 1) clock edges after the first strobe is sampled.
- R8: `out_settle` is high only together with `out_valid`. It is high on the first 5 outputs after `sync` at ratio 8, and on the first 4 outputs at other ratios.
- R9: The arithmetic never overflows. A constant all-ones input settles at +327680000 at ratio 80, and an all-zeros input settles at −327680000.
- R10: After reset, `out_valid`, `out_settle` and `out_data` are all zero.
- R11: Cycles without `mod_stb` change no state. Bit values present in those cycles are ignored, and no output is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync | input | 1 | Clears filter state and phase |
| mod_stb | input | 1 | One pulse per modulator bit |
| mod_bits | input | 4 | One modulator bit per channel |
| ratio_sel | input | 2 | Bit 0 enables the ratio-2 section, bit 1 enables the ratio-5 section |
| out_valid | output | 1 | Output sample strobe |
| out_settle | output | 1 | Marks outputs still inside the settling window |
| out_data | output | 132 | Four signed 33-bit samples, channel 0 in the low bits |

## Verification
Every ratio setting is driven with independent pseudo-random streams, which expose any mistake in tap weights, section order or decimation phase against a direct moving-sum model. Constant all-ones and all-zeros inputs show that the register widths and the sign hold at full scale. A mixed set with one constant, one alternating and one random channel separates channel crosstalk from shared timing. Gapped strobes with garbage bits between them, idle spells, and a `sync` issued mid-stream with a strobe in the same cycle test stalling and realignment.

// File: rtl/sinc_cic_stage.sv
module sinc_cic_stage #(
  parameter int NCH   = 4,
  parameter int ORD   = 5,
  parameter int RATIO = 8,
  parameter int IW    = 2,
  parameter int OW    = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                in_stb,
  input  logic [NCH*IW-1:0]   in_data,
  output logic                out_stb,
  output logic [NCH*OW-1:0]   out_data
);
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0]        phase;
  logic signed [OW-1:0] integ    [NCH][ORD];
  logic signed [OW-1:0] integ_nx [NCH][ORD];
  logic signed [OW-1:0] dly      [NCH][ORD];
  logic signed [OW-1:0] comb_in  [NCH][ORD];
  logic signed [OW-1:0] comb_out [NCH];

  wire wrap = in_stb && (phase == LAST);

  always_comb begin
    logic signed [OW-1:0] acc;
    for (int c = 0; c < NCH; c++) begin
      acc = {{(OW-IW){in_data[c*IW+IW-1]}}, in_data[c*IW +: IW]};
      for (int k = 0; k < ORD; k++) begin
        acc = integ[c][k] + acc;
        integ_nx[c][k] = acc;
      end
      for (int k = 0; k < ORD; k++) begin
        comb_in[c][k] = acc;
        acc = acc - dly[c][k];
      end
      comb_out[c] = acc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      phase    <= '0;
      out_stb  <= 1'b0;
      out_data <= '0;
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < ORD; k++) begin
          integ[c][k] <= '0;
          dly[c][k]   <= '0;
        end
    end else begin
      out_stb <= wrap;
      if (in_stb) begin
        phase <= wrap ? '0 : phase + 1'b1;
        for (int c = 0; c < NCH; c++)
          for (int k = 0; k < ORD; k++)
            integ[c][k] <= integ_nx[c][k];
      end
      if (wrap) begin
        for (int c = 0; c < NCH; c++) begin
          out_data[c*OW +: OW] <= comb_out[c];
          for (int k = 0; k < ORD; k++)
            dly[c][k] <= comb_in[c][k];
        end
      end
    end
  end
endmodule

// File: rtl/sinc_decim_cascade.sv
module sinc_decim_cascade #(
  parameter int NCH      = 4,
  parameter int S1_ORD   = 5,
  parameter int S1_RATIO = 8,
  parameter int S2_ORD   = 4,
  parameter int S2_RATIO = 2,
  parameter int S3_ORD   = 4,
  parameter int S3_RATIO = 5,
  localparam int W1 = 2 + S1_ORD * $clog2(S1_RATIO),
  localparam int W2 = W1 + S2_ORD * $clog2(S2_RATIO),
  localparam int OW = W2 + S3_ORD * $clog2(S3_RATIO)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync,
  input  logic                mod_stb,
  input  logic [NCH-1:0]      mod_bits,
  input  logic [1:0]          ratio_sel,
  output logic                out_valid,
  output logic                out_settle,
  output logic [NCH*OW-1:0]   out_data
);
  logic [NCH*2-1:0]  s1_in;
  logic [NCH*W1-1:0] s1_out;
  logic [NCH*W2-1:0] s2_out, s3_in;
  logic [NCH*OW-1:0] s3_out;
  logic              s1_stb, s2_stb, s3_stb, s3_in_stb;
  logic [2:0]        cnt, lim;

  for (genvar c = 0; c < NCH; c++) begin : g_map
    assign s1_in[c*2 +: 2] = mod_bits[c] ? 2'b01 : 2'b11;
    assign s3_in[c*W2 +: W2] = ratio_sel[0] ? s2_out[c*W2 +: W2]
                             : {{(W2-W1){s1_out[c*W1+W1-1]}}, s1_out[c*W1 +: W1]};
  end
  assign s3_in_stb = ratio_sel[0] ? s2_stb : s1_stb;

  sinc_cic_stage #(.NCH(NCH), .ORD(S1_ORD), .RATIO(S1_RATIO), .IW(2), .OW(W1)) u_s1 (
    .clk(clk), .rst_n(rst_n), .clr(sync), .in_stb(mod_stb), .in_data(s1_in),
    .out_stb(s1_stb), .out_data(s1_out));

  sinc_cic_stage #(.NCH(NCH), .ORD(S2_ORD), .RATIO(S2_RATIO), .IW(W1), .OW(W2)) u_s2 (
    .clk(clk), .rst_n(rst_n), .clr(sync), .in_stb(s1_stb), .in_data(s1_out),
    .out_stb(s2_stb), .out_data(s2_out));

  sinc_cic_stage #(.NCH(NCH), .ORD(S3_ORD), .RATIO(S3_RATIO), .IW(W2), .OW(OW)) u_s3 (
    .clk(clk), .rst_n(rst_n), .clr(sync), .in_stb(s3_in_stb), .in_data(s3_in),
    .out_stb(s3_stb), .out_data(s3_out));

  always_comb begin
    case (ratio_sel)
      2'b00: out_valid = s1_stb;
      2'b01: out_valid = s2_stb;
      default: out_valid = s3_stb;
    endcase
    for (int c = 0; c < NCH; c++) begin
      case (ratio_sel)
        2'b00: out_data[c*OW +: OW] = {{(OW-W1){s1_out[c*W1+W1-1]}}, s1_out[c*W1 +: W1]};
        2'b01: out_data[c*OW +: OW] = {{(OW-W2){s2_out[c*W2+W2-1]}}, s2_out[c*W2 +: W2]};
        default: out_data[c*OW +: OW] = s3_out[c*OW +: OW];
      endcase
    end
  end

  assign lim = (ratio_sel == 2'b00) ? 3'(S1_ORD) : (ratio_sel[1] ? 3'(S3_ORD) : 3'(S2_ORD));
  assign out_settle = out_valid && (cnt < lim);

  always_ff @(posedge clk) begin
    if (!rst_n || sync) cnt <= '0;
    else if (out_valid && cnt != 3'd7) cnt <= cnt + 1'b1;
  end
endmodule

module sinc_decim_checker #(
  parameter int NCH = 4,
  parameter int OW  = 33,
  parameter int FS  = 327680000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync,
  input logic              mod_stb,
  input logic [1:0]        ratio_sel,
  input logic              out_valid,
  input logic              out_settle,
  input logic [NCH*OW-1:0] out_data
);
  localparam logic signed [OW-1:0] FS_POS = OW'(FS);
  localparam logic signed [OW-1:0] FS_NEG = -FS_POS;

  assert_needs_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ratio_sel == 2'b00) |-> $past(mod_stb));

  assert_sync_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !out_valid);

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_settle_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_settle |-> out_valid);

  for (genvar c = 0; c < NCH; c++) begin : g_fs
    wire signed [OW-1:0] smp = out_data[c*OW +: OW];
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (smp <= FS_POS && smp >= FS_NEG));
  end
endmodule

bind sinc_decim_cascade sinc_decim_checker #(
  .NCH(NCH), .OW(OW),
  .FS((S1_RATIO ** S1_ORD) * (S2_RATIO ** S2_ORD) * (S3_RATIO ** S3_ORD))
) u_chk (
  .clk(clk), .rst_n(rst_n), .sync(sync), .mod_stb(mod_stb), .ratio_sel(ratio_sel),
  .out_valid(out_valid), .out_settle(out_settle), .out_data(out_data));

// File: tb/sinc_decim_cascade_tb.sv
module sinc_decim_cascade_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int OW  = 33;
  localparam longint FULL = 327680000;

  logic clk = 1'b0, rst_n = 1'b0, sync = 1'b0, mod_stb = 1'b0;
  logic [NCH-1:0] mod_bits = '0;
  logic [1:0] ratio_sel = 2'b00;
  logic out_valid, out_settle;
  logic [NCH*OW-1:0] out_data;

  sinc_decim_cascade u_dut (
    .clk(clk), .rst_n(rst_n), .sync(sync), .mod_stb(mod_stb), .mod_bits(mod_bits),
    .ratio_sel(ratio_sel), .out_valid(out_valid), .out_settle(out_settle),
    .out_data(out_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint got_v [NCH][64];
  bit     got_s [64];
  int     got_t [64];
  int     got_n = 0;

  always @(negedge clk) begin
    if (out_valid && got_n < 64) begin
      for (int c = 0; c < NCH; c++) got_v[c][got_n] = $signed(out_data[c*OW +: OW]);
      got_s[got_n] = out_settle;
      got_t[got_n] = cyc;
      got_n++;
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  int unsigned lf [NCH] = '{32'h1234567, 32'h9abcdef1, 32'h2468ace, 32'h13579bd};
  function automatic bit rnd(int c);
    lf[c] = lf[c] ^ (lf[c] << 13);
    lf[c] = lf[c] ^ (lf[c] >> 17);
    lf[c] = lf[c] ^ (lf[c] << 5);
    return lf[c][3];
  endfunction

  longint sig [0:1023];
  longint tmp [0:1023];
  int     sig_len;
  bit     xin [NCH][0:1023];
  longint expv [NCH][64];
  int     exp_n;

  task automatic boxcar(int r, int ord);
    longint s;
    for (int p = 0; p < ord; p++) begin
      for (int n = 0; n < sig_len; n++) begin
        s = 0;
        for (int k = 0; k < r; k++) if (n - k >= 0) s += sig[n-k];
        tmp[n] = s;
      end
      for (int n = 0; n < sig_len; n++) sig[n] = tmp[n];
    end
    sig_len = sig_len / r;
    for (int m = 0; m < sig_len; m++) sig[m] = sig[m*r + r - 1];
  endtask

  task automatic run_case(string tag, logic [1:0] sel, int pat, int n_out,
                          bit gap, bit dirty, int idle);
    int ratio, n_in, stages, lim, c0;
    ratio  = 8 * (sel[0] ? 2 : 1) * (sel[1] ? 5 : 1);
    stages = 1 + int'(sel[0]) + int'(sel[1]);
    n_in   = n_out * ratio;
    lim    = (sel == 2'b00) ? 5 : 4;
    for (int c = 0; c < NCH; c++)
      for (int n = 0; n < n_in; n++)
        case (pat)
          0: xin[c][n] = 1'b1;
          1: xin[c][n] = 1'b0;
          2: xin[c][n] = rnd(c);
          default: xin[c][n] = (c == 0) ? 1'b1 : (c == 1) ? 1'b0 : (c == 2) ? bit'(n % 2) : rnd(c);
        endcase
    for (int c = 0; c < NCH; c++) begin
      sig_len = n_in;
      for (int n = 0; n < n_in; n++) sig[n] = xin[c][n] ? 1 : -1;
      boxcar(8, 5);
      if (sel[0]) boxcar(2, 4);
      if (sel[1]) boxcar(5, 4);
      for (int m = 0; m < sig_len && m < 64; m++) expv[c][m] = sig[m];
      exp_n = sig_len;
    end
    @(posedge clk); #1;
    ratio_sel = sel;
    if (dirty)
      repeat (13) begin
        mod_stb = 1'b1;
        for (int c = 0; c < NCH; c++) mod_bits[c] = rnd(c);
        @(posedge clk); #1;
      end
    sync = 1'b1; mod_stb = dirty; mod_bits = '1;
    @(posedge clk); #1;
    sync = 1'b0; mod_stb = 1'b0; got_n = 0;
    if (idle > 0) begin
      repeat (idle) begin
        for (int c = 0; c < NCH; c++) mod_bits[c] = rnd(c);
        @(posedge clk); #1;
      end
      chk("R11", "outputs during idle", got_n, 0);
    end
    c0 = cyc;
    for (int n = 0; n < n_in; n++) begin
      mod_stb = 1'b1;
      for (int c = 0; c < NCH; c++) mod_bits[c] = xin[c][n];
      @(posedge clk); #1;
      if (gap) begin
        mod_stb = 1'b0;
        for (int c = 0; c < NCH; c++) mod_bits[c] = rnd(c);
        @(posedge clk); #1;
        @(posedge clk); #1;
      end
    end
    mod_stb = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    chk(tag, "output count", got_n, exp_n);
    for (int j = 0; j < got_n && j < exp_n; j++) begin
      for (int c = 0; c < NCH; c++)
        chk(tag, $sformatf("ch%0d sample %0d", c, j), got_v[c][j], expv[c][j]);
      chk("R8", $sformatf("settle flag %0d", j), longint'(got_s[j]), longint'(j < lim));
      if (!gap)
        chk("R7", $sformatf("arrival cycle %0d", j), got_t[j], c0 + ratio*(j+1) + stages - 1);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R10", "out_valid after reset", out_valid, 0);
    chk("R10", "out_settle after reset", out_settle, 0);
    chk("R10", "out_data after reset", longint'(out_data != '0), 0);
  endtask

  task automatic test_ratio8();  run_case("R1", 2'b00, 2, 10, 0, 0, 0); endtask
  task automatic test_ratio16(); run_case("R2", 2'b01, 2, 8, 0, 0, 0);  endtask
  task automatic test_ratio40(); run_case("R3", 2'b10, 2, 5, 0, 0, 0);  endtask
  task automatic test_ratio80(); run_case("R4", 2'b11, 2, 6, 0, 0, 0);  endtask

  task automatic test_channels();
    run_case("R5", 2'b00, 3, 10, 0, 0, 0);
    run_case("R5", 2'b10, 3, 4, 0, 0, 0);
  endtask

  task automatic test_full_scale();
    run_case("R9", 2'b11, 0, 6, 0, 0, 0);
    for (int c = 0; c < NCH; c++) chk("R9", "positive full scale", got_v[c][5], FULL);
    run_case("R9", 2'b11, 1, 6, 0, 0, 0);
    for (int c = 0; c < NCH; c++) chk("R9", "negative full scale", got_v[c][5], -FULL);
  endtask

  task automatic test_resync(); run_case("R6", 2'b01, 2, 6, 0, 1, 0); endtask
  task automatic test_stall();  run_case("R11", 2'b10, 2, 4, 1, 0, 20); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL all watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    test_reset();
    #1 rst_n = 1'b1;
    test_reset();
    test_ratio8();
    test_ratio16();
    test_ratio40();
    test_ratio80();
    test_channels();
    test_full_scale();
    test_resync();
    test_stall();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule